// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This unit watches the bus cycles of a processor and raises a break request when a programmed watchpoint condition is met. It has two comparison channels, A and B. Each compares the bus address against a programmed address under a per-bit mask. Each also checks which bus the cycle ran on, whether it was an instruction fetch or a data access, its direction and, if asked, its operand size. Channel B can also compare the transferred data against a programmed value under a data mask.

The two channels either fire on their own (independent mode) or form a two-step sequence in which channel A arms the unit and a later channel B hit fires it. Configuration is written through a small register port. A write only takes effect after a fixed pipeline delay. A register read is held off until every pending write is active, so software can read back the last written register to know when new settings apply. Each channel keeps a sticky hit flag that software reads and clears.

Top module: `brk_unit`

## Requirements
- R1: Channel address compare is per bit: a bit set in the channel's address mask is ignored, and a zero mask demands an exact match of all address bits.
- R2: Channel B also needs `((bus_data ^ value) & ~dmask)` to be zero over the lanes of the access. A byte access (`bus_size`=01) uses bits 7:0 only, a word access (10) bits 15:0, and a longword access (11) all bits.
- R3: The condition register of a channel (bits [1:0] kind, [2] read, [3] write, [4] bus, [6:5] size) gates every hit. Kind 01 takes fetches only, 10 data accesses only, and 11 either. Bit 2 admits reads and bit 3 admits writes. Bit 4 must equal `bus_sel_l`. A size field of 00 accepts any size; any other value must equal `bus_size`. A cycle with `bus_valid` low never hits.
- R4: A channel whose kind field is 00 never hits. Every condition register resets to zero, so both channels are off after reset.
- R5: In independent mode (control bit 0 = 0), a hit on either channel drives `brk_req` high for exactly the clock cycle after that bus cycle.
- R6: In sequential mode (control bit 0 = 1), `brk_req` rises only for a channel B hit in a bus cycle strictly later than a channel A hit. A cycle in which both channels hit does not fire, but it does arm the unit.
- R7: After a sequential break fires, the unit is disarmed. A further break needs a fresh channel A hit, even when channel A also hits in the firing cycle.
- R8: Control bits 1 and 2 are sticky hit flags for channels A and B. They set on any hit in either mode. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R9: A register write is active from the bus cycle LAT+1 clocks after the write edge. Before then, bus cycles use the old value, and `reg_ack` stays low for a read while any write is pending.
- R10: After reset, `brk_req` is low and every register reads zero. Register indices: 0 A address, 1 A address mask, 2 A condition, 3 B address, 4 B address mask, 5 B condition, 6 B data value, 7 B data mask, 8 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one per cycle |
| reg_rd | input | 1 | Register read request, held until `reg_ack` |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data, valid with `reg_ack` |
| reg_ack | output | 1 | Read completes this cycle |
| bus_valid | input | 1 | A bus cycle is present |
| bus_sel_l | input | 1 | 0: first bus, 1: second bus |
| bus_fetch | input | 1 | 1: instruction fetch, 0: data access |
| bus_write | input | 1 | 1: write, 0: read |
| bus_size | input | 2 | 01 byte, 10 word, 11 longword |
| bus_addr | input | W | Bus address |
| bus_data | input | W | Bus data |
| brk_req | output | 1 | Break request pulse |

## Verification
The assertions assume that every valid bus cycle carries a size code of 01, 10 or 11, never 00. They also assume that a register read is not issued in the same cycle as a write to the register being read. The stimulus drives only legal size codes and always waits for a write to be accepted before it reads. Bus cycles are kept one per clock, so each `brk_req` sample belongs to exactly one presented cycle. This holds in the sequential tests, where arming and firing must land in separate cycles.

// File: rtl/brk_pkg.sv
package brk_pkg;
    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_FETCH = 2'd1,
        KIND_DATA  = 2'd2,
        KIND_ANY   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        SZ_ANY  = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } size_e;

    // bit order is the software-visible layout: size[6:5] bus[4] wr[3] rd[2] kind[1:0]
    typedef struct packed {
        size_e size;
        logic  bus_l;
        logic  on_wr;
        logic  on_rd;
        kind_e kind;
    } cond_t;

    localparam int COND_W = $bits(cond_t);
    localparam int RIDX_W = 4;

    localparam logic [RIDX_W-1:0] RG_A_ADDR  = 4'd0;
    localparam logic [RIDX_W-1:0] RG_A_AMASK = 4'd1;
    localparam logic [RIDX_W-1:0] RG_A_COND  = 4'd2;
    localparam logic [RIDX_W-1:0] RG_B_ADDR  = 4'd3;
    localparam logic [RIDX_W-1:0] RG_B_AMASK = 4'd4;
    localparam logic [RIDX_W-1:0] RG_B_COND  = 4'd5;
    localparam logic [RIDX_W-1:0] RG_B_DATA  = 4'd6;
    localparam logic [RIDX_W-1:0] RG_B_DMASK = 4'd7;
    localparam logic [RIDX_W-1:0] RG_CTRL    = 4'd8;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      a_addr,
    output logic [W-1:0]      a_amask,
    output cond_t             a_cond,
    output logic [W-1:0]      b_addr,
    output logic [W-1:0]      b_amask,
    output logic [W-1:0]      b_data,
    output logic [W-1:0]      b_dmask,
    output cond_t             b_cond,
    output logic              seq_mode,
    output logic              ctrl_wr,
    output logic              keep_a,
    output logic              keep_b,
    output logic              pending
);
    typedef struct packed {
        logic [LAT-1:0]             pv;
        logic [LAT-1:0][RIDX_W-1:0] pa;
        logic [LAT-1:0][W-1:0]      pd;
        logic [W-1:0]               a_addr;
        logic [W-1:0]               a_amask;
        logic [W-1:0]               b_addr;
        logic [W-1:0]               b_amask;
        logic [W-1:0]               b_data;
        logic [W-1:0]               b_dmask;
        cond_t                      a_cond;
        cond_t                      b_cond;
        logic                       seq;
    } st_t;

    st_t st_d, st_q;

    logic [LAT:0]             pv_x;
    logic [LAT:0][RIDX_W-1:0] pa_x;
    logic [LAT:0][W-1:0]      pd_x;
    logic [RIDX_W-1:0]        tail_a;
    logic [W-1:0]             tail_d;

    assign tail_a = st_q.pa[LAT-1];
    assign tail_d = st_q.pd[LAT-1];

    always_comb begin
        st_d = st_q;
        pv_x = {st_q.pv, wr};
        pa_x = {st_q.pa, waddr};
        pd_x = {st_q.pd, wdata};
        st_d.pv = pv_x[LAT-1:0];
        st_d.pa = pa_x[LAT-1:0];
        st_d.pd = pd_x[LAT-1:0];
        if (st_q.pv[LAT-1]) begin
            case (tail_a)
                RG_A_ADDR:  st_d.a_addr  = tail_d;
                RG_A_AMASK: st_d.a_amask = tail_d;
                RG_A_COND:  st_d.a_cond  = cond_t'(tail_d[COND_W-1:0]);
                RG_B_ADDR:  st_d.b_addr  = tail_d;
                RG_B_AMASK: st_d.b_amask = tail_d;
                RG_B_COND:  st_d.b_cond  = cond_t'(tail_d[COND_W-1:0]);
                RG_B_DATA:  st_d.b_data  = tail_d;
                RG_B_DMASK: st_d.b_dmask = tail_d;
                RG_CTRL:    st_d.seq     = tail_d[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_addr   = st_q.a_addr;
    assign a_amask  = st_q.a_amask;
    assign a_cond   = st_q.a_cond;
    assign b_addr   = st_q.b_addr;
    assign b_amask  = st_q.b_amask;
    assign b_data   = st_q.b_data;
    assign b_dmask  = st_q.b_dmask;
    assign b_cond   = st_q.b_cond;
    assign seq_mode = st_q.seq;
    assign ctrl_wr  = st_q.pv[LAT-1] && (tail_a == RG_CTRL);
    assign keep_a   = tail_d[1];
    assign keep_b   = tail_d[2];
    assign pending  = |st_q.pv;

    // R9: an accepted write leaves the port busy on the next cycle
    assert_wr_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> pending);
endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter int W        = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ref_addr,
    input  logic [W-1:0] ref_amask,
    input  logic [W-1:0] ref_data,
    input  logic [W-1:0] ref_dmask,
    input  cond_t        cond,
    input  logic         bus_valid,
    input  logic         bus_sel_l,
    input  logic         bus_fetch,
    input  logic         bus_write,
    input  logic [1:0]   bus_size,
    input  logic [W-1:0] bus_addr,
    input  logic [W-1:0] bus_data,
    output logic         hit
);
    localparam int BW = (W < 8)  ? W : 8;
    localparam int HW = (W < 16) ? W : 16;

    logic kind_ok, dir_ok, bus_ok, size_ok, addr_ok, data_ok;

    always_comb begin
        case (cond.kind)
            KIND_FETCH: kind_ok = bus_fetch;
            KIND_DATA:  kind_ok = !bus_fetch;
            KIND_ANY:   kind_ok = 1'b1;
            default:    kind_ok = 1'b0;
        endcase
        dir_ok  = bus_write ? cond.on_wr : cond.on_rd;
        bus_ok  = (bus_sel_l == cond.bus_l);
        size_ok = (cond.size == SZ_ANY) || (cond.size == size_e'(bus_size));
        addr_ok = ((bus_addr ^ ref_addr) & ~ref_amask) == '0;
    end

    generate
        if (HAS_DATA) begin : g_data
            logic [W-1:0] lanes;
            always_comb begin
                case (size_e'(bus_size))
                    SZ_BYTE: lanes = W'({BW{1'b1}});
                    SZ_WORD: lanes = W'({HW{1'b1}});
                    default: lanes = '1;
                endcase
                data_ok = ((bus_data ^ ref_data) & ~ref_dmask & lanes) == '0;
            end
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{ref_data, ref_dmask, bus_data};
            assign data_ok = 1'b1;
        end
    endgenerate

    assign hit = bus_valid && kind_ok && dir_ok && bus_ok && size_ok && addr_ok && data_ok;

    // R4: a channel without a cycle kind stays silent
    assert_off_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond.kind == KIND_NONE) |-> !hit);
    // R3: a fixed size condition rejects other sizes
    assert_size_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond.size != SZ_ANY && size_e'(bus_size) != cond.size) |-> !hit);
    // R3: an idle bus never hits
    assert_idle_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !hit);
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_a,
    input  logic hit_b,
    input  logic seq_mode,
    input  logic ctrl_wr,
    input  logic keep_a,
    input  logic keep_b,
    output logic brk,
    output logic sticky_a,
    output logic sticky_b
);
    typedef struct packed {
        logic armed;
        logic brk;
        logic sa;
        logic sb;
    } st_t;

    st_t st_d, st_q;
    logic fire;

    always_comb begin
        st_d = st_q;
        fire = seq_mode ? (hit_b && st_q.armed) : (hit_a || hit_b);
        st_d.brk = fire;
        if (!seq_mode)   st_d.armed = 1'b0;
        else if (fire)   st_d.armed = 1'b0;
        else if (hit_a)  st_d.armed = 1'b1;
        if (hit_a)                  st_d.sa = 1'b1;
        else if (ctrl_wr && !keep_a) st_d.sa = 1'b0;
        if (hit_b)                  st_d.sb = 1'b1;
        else if (ctrl_wr && !keep_b) st_d.sb = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk      = st_q.brk;
    assign sticky_a = st_q.sa;
    assign sticky_b = st_q.sb;

    // R5: any hit in independent mode requests a break next cycle
    assert_indep_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_mode && (hit_a || hit_b)) |=> brk);
    // R6: no break in sequence mode without an earlier A hit
    assert_need_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && !st_q.armed) |=> !brk);
    // R7: a sequential break leaves the unit disarmed
    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_mode && hit_b && st_q.armed) |=> !st_q.armed);
    // R8: hits always set the sticky flags
    assert_sticky_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> sticky_a);
    assert_sticky_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> sticky_b);
endmodule

// File: rtl/brk_unit.sv
module brk_unit
    import brk_pkg::*;
#(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              reg_ack,
    input  logic              bus_valid,
    input  logic              bus_sel_l,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_size,
    input  logic [W-1:0]      bus_addr,
    input  logic [W-1:0]      bus_data,
    output logic              brk_req
);
    localparam int PAD = W - COND_W;

    logic [W-1:0] a_addr, a_amask, b_addr, b_amask, b_data, b_dmask;
    cond_t        a_cond, b_cond;
    logic         seq_mode, ctrl_wr, keep_a, keep_b, pending;
    logic         hit_a, hit_b, sticky_a, sticky_b;

    brk_regs #(.W(W), .LAT(LAT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr), .wdata(reg_wdata),
        .a_addr(a_addr), .a_amask(a_amask), .a_cond(a_cond),
        .b_addr(b_addr), .b_amask(b_amask), .b_data(b_data), .b_dmask(b_dmask),
        .b_cond(b_cond), .seq_mode(seq_mode), .ctrl_wr(ctrl_wr),
        .keep_a(keep_a), .keep_b(keep_b), .pending(pending)
    );

    brk_chan #(.W(W), .HAS_DATA(1'b0)) u_chan_a (
        .clk(clk), .rst_n(rst_n),
        .ref_addr(a_addr), .ref_amask(a_amask), .ref_data('0), .ref_dmask('0),
        .cond(a_cond), .bus_valid(bus_valid), .bus_sel_l(bus_sel_l),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_data(bus_data), .hit(hit_a)
    );

    brk_chan #(.W(W), .HAS_DATA(1'b1)) u_chan_b (
        .clk(clk), .rst_n(rst_n),
        .ref_addr(b_addr), .ref_amask(b_amask), .ref_data(b_data), .ref_dmask(b_dmask),
        .cond(b_cond), .bus_valid(bus_valid), .bus_sel_l(bus_sel_l),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_data(bus_data), .hit(hit_b)
    );

    brk_seq u_seq (
        .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
        .seq_mode(seq_mode), .ctrl_wr(ctrl_wr), .keep_a(keep_a), .keep_b(keep_b),
        .brk(brk_req), .sticky_a(sticky_a), .sticky_b(sticky_b)
    );

    always_comb begin
        case (reg_addr)
            RG_A_ADDR:  reg_rdata = a_addr;
            RG_A_AMASK: reg_rdata = a_amask;
            RG_A_COND:  reg_rdata = {{PAD{1'b0}}, a_cond};
            RG_B_ADDR:  reg_rdata = b_addr;
            RG_B_AMASK: reg_rdata = b_amask;
            RG_B_COND:  reg_rdata = {{PAD{1'b0}}, b_cond};
            RG_B_DATA:  reg_rdata = b_data;
            RG_B_DMASK: reg_rdata = b_dmask;
            RG_CTRL:    reg_rdata = W'({sticky_b, sticky_a, seq_mode});
            default:    reg_rdata = '0;
        endcase
    end

    assign reg_ack = reg_rd && !pending;

    // R9: a read never completes in the cycle after a write
    assert_read_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_ack);
endmodule

// File: tb/sim_brk_unit.sv
`timescale 1ns/1ps
module sim_brk_unit;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic [W-1:0]  reg_rdata;
    logic          reg_ack;
    logic          bus_valid = 1'b0, bus_sel_l = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0;
    logic [1:0]    bus_size = 2'd3;
    logic [W-1:0]  bus_addr = '0, bus_data = '0;
    logic          brk_req;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    brk_unit #(.W(W), .LAT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .bus_valid(bus_valid), .bus_sel_l(bus_sel_l),
        .bus_fetch(bus_fetch), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_data(bus_data), .brk_req(brk_req)
    );

    typedef struct packed {
        logic        valid;
        logic        sel_l;
        logic        fetch;
        logic        write;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] data;
        logic        exp;
    } vec_t;

    // independent mode, A: fetch/read/first bus at 0x00314156; B: byte write 0x7x at 0x00055555
    localparam vec_t VEC [12] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 32'h00314156, 32'h0,        1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'd3, 32'h00314157, 32'h0,        1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 32'h00314156, 32'h0,        1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 32'h00314156, 32'h0,        1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00055555, 32'h0000007A, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00055555, 32'h00000085, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00055555, 32'hFFFFFF7F, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 32'h00055555, 32'h00000070, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h00055555, 32'h0000007A, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 32'h00055555, 32'h00000070, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 32'h00314156, 32'h0,        1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h00055554, 32'h0000007A, 1'b0}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [W-1:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        for (int i = 0; i < 20; i++) begin
            if (reg_ack) break;
            @(negedge clk);
        end
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic bus(input logic v, input logic s, input logic f, input logic w,
                       input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                       input logic exp, input string req);
        @(negedge clk);
        bus_valid = v; bus_sel_l = s; bus_fetch = f; bus_write = w;
        bus_size = sz; bus_addr = a; bus_data = d;
        @(posedge clk); #1;
        chk(req, W'(brk_req), W'(exp));
        bus_valid = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] rv;
        #9 rst_n = 1'b1;
        #1;
        // R10 reset state
        chk("R10 brk after reset", W'(brk_req), '0);
        rd_reg(4'd2, rv); chk("R10 A cond reset", rv, '0);
        rd_reg(4'd8, rv); chk("R10 ctrl reset", rv, '0);
        // R4: reset conditions disabled, address 0 would otherwise match
        bus(1, 0, 1, 0, 2'd3, 32'h0, 32'h0, 1'b0, "R4 disabled after reset");
        bus(1, 0, 0, 1, 2'd1, 32'h0, 32'h0, 1'b0, "R4 disabled B after reset");

        wr_reg(4'd0, 32'h00314156);
        wr_reg(4'd1, 32'h0);
        wr_reg(4'd2, 32'h05);
        wr_reg(4'd3, 32'h00055555);
        wr_reg(4'd4, 32'h0);
        wr_reg(4'd5, 32'h2A);
        wr_reg(4'd6, 32'h78);
        wr_reg(4'd7, 32'h0F);
        idle(4);

        foreach (VEC[i]) begin
            bus(VEC[i].valid, VEC[i].sel_l, VEC[i].fetch, VEC[i].write, VEC[i].size,
                VEC[i].addr, VEC[i].data, VEC[i].exp, $sformatf("R1/R2/R3/R5 vector %0d", i));
        end
        // R5: pulse drops with an idle bus
        idle(1);
        chk("R5 pulse ends", W'(brk_req), '0);

        // R8 sticky flags
        rd_reg(4'd8, rv); chk("R8 sticky set", rv, 32'h6);
        wr_reg(4'd8, 32'h4);
        rd_reg(4'd8, rv); chk("R8 clear A keep B", rv, 32'h4);
        wr_reg(4'd8, 32'h0);
        rd_reg(4'd8, rv); chk("R8 clear B", rv, 32'h0);

        // R1 mask
        wr_reg(4'd1, 32'h0000000F);
        idle(4);
        bus(1, 0, 1, 0, 2'd3, 32'h0031415A, 32'h0, 1'b1, "R1 masked bits ignored");
        bus(1, 0, 1, 0, 2'd3, 32'h00314146, 32'h0, 1'b0, "R1 unmasked bit compared");

        // R9 write latency and read hold-off
        wr_reg(4'd0, 32'h00001000);
        chk("R9 ack held while pending", W'(reg_rd ? reg_ack : 1'b0), '0);
        reg_rd = 1'b1; reg_addr = 4'd0; #0;
        chk("R9 read not acked", W'(reg_ack), '0);
        reg_rd = 1'b0;
        bus(1, 0, 1, 0, 2'd3, 32'h00001000, 32'h0, 1'b0, "R9 old value in use");
        rd_reg(4'd0, rv); chk("R9 readback new value", rv, 32'h00001000);
        bus(1, 0, 1, 0, 2'd3, 32'h00001000, 32'h0, 1'b1, "R9 new value in use");

        // R6 / R7 sequential mode
        wr_reg(4'd8, 32'h1);
        idle(4);
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b0, "R6 B alone no break");
        bus(1, 0, 1, 0, 2'd3, 32'h00001000, 32'h0,  1'b0, "R6 A arms only");
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b1, "R6 B after A fires");
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b0, "R7 disarmed after fire");
        bus(1, 0, 1, 0, 2'd3, 32'h00001000, 32'h0,  1'b0, "R6 A again");
        idle(2);
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h71, 1'b1, "R6 B later fires");

        // channel A now matches the same byte write as channel B
        wr_reg(4'd0, 32'h00055555);
        wr_reg(4'd1, 32'h0);
        wr_reg(4'd2, 32'h0A);
        idle(4);
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b0, "R6 same-cycle A and B no break");
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b1, "R6 armed by earlier cycle");
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b0, "R7 A in firing cycle does not rearm");
        bus(1, 0, 0, 1, 2'd1, 32'h00055555, 32'h7A, 1'b1, "R7 fresh arm then fire");

        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule